// File: doc/BRIEF.md
# Host Slot to ATA Register Bridge

This block sits between the 8-bit expansion-slot bus of a small host computer and the register port of a parallel ATA drive. The slot bus gives each card an active-low device-select strobe that is already decoded for that slot's 16-byte I/O window. The bridge passes that strobe to the drive as its chip select. It combines the strobe with the host read/write line and an active-low phase qualifier to form the drive's separate active-low read and write strobes. It forwards the low three host address bits as the drive register number.

The drive's data register is 16 bits wide and the host bus is 8 bits wide, so the bridge keeps one shared high-byte latch. A host read of window offset 0 returns the low byte of the drive word at once. In the same cycle it captures the upper byte into the latch, and the host collects that byte later at offset 8. For a write, the host first stores the upper byte at offset 8, which touches only the latch. It then writes the low byte at offset 0, and the bridge presents the complete word to the drive with a single write strobe. Offsets 1 to 7 reach the other task-file registers as 8-bit registers. Offsets 9 to 15 are unused.

The host side has no valid/ready handshake. A host cycle is the time the qualifier and device select are both low, and the drive must answer within that cycle. No back-pressure exists at either edge. Strobes and read data are combinational from the host pins. The latch loads on `clk` while a qualifying access is active.

Top module: `hostslot_ata_bridge`

## Requirements
- R1: `ata_cs_n` equals `dev_sel_n` at all times.
- R2: `ata_da` equals `host_addr[2:0]` at all times.
- R3: `ata_ior_n` is low only when `dev_sel_n`=0, `phase_n`=0, `host_rw`=1 (1 means read) and `host_addr[3]`=0. Otherwise it is high.
- R4: `ata_iow_n` is low only when `dev_sel_n`=0, `phase_n`=0, `host_rw`=0 and `host_addr[3]`=0. Otherwise it is high.
- R5: When `dev_sel_n` or `phase_n` is high, both strobes are high. The two strobes are never low together.
- R6: A read at offset 0 returns `ata_din[7:0]` on `host_rd_data`, and the clock edge during that read captures `ata_din[15:8]` into the high-byte latch. A later read at offset 8 returns the latch and asserts no drive strobe.
- R7: A write at offset 8 loads `host_wr_data` into the latch on the clock edge and asserts no drive strobe. A write at offset 0 drives `{latch, host_wr_data}` on `ata_dout` with `ata_dout_oe`=1 and `ata_iow_n` low.
- R8: `host_rd_oe` is 1 only during an active read (`dev_sel_n`=0, `phase_n`=0, `host_rw`=1). Whenever `host_rd_oe` is 0, `host_rd_data` is 0x00.
- R9: Reset clears the high-byte latch, so a read at offset 8 that comes before any capture or load returns 0x00.
- R10: Writes at offsets 1 to 7 drive `{8'h00, host_wr_data}`. Reads at those offsets return `ata_din[7:0]`. Neither changes the latch.
- R11: Reads at offsets 9 to 15 return 0x00. Writes there leave the latch unchanged. Neither asserts a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the high-byte latch |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel_n | input | 1 | Slot device select, active low |
| phase_n | input | 1 | Bus phase qualifier, active low |
| host_rw | input | 1 | 1 = host read, 0 = host write |
| host_addr | input | 4 | Offset within the slot I/O window |
| host_wr_data | input | 8 | Host write data |
| host_rd_data | output | 8 | Host read data, 0x00 when not enabled |
| host_rd_oe | output | 1 | Host data bus drive enable |
| ata_cs_n | output | 1 | Drive chip select, active low |
| ata_da | output | 3 | Drive register address |
| ata_ior_n | output | 1 | Drive read strobe, active low |
| ata_iow_n | output | 1 | Drive write strobe, active low |
| ata_din | input | 16 | Data word from the drive |
| ata_dout | output | 16 | Data word to the drive |
| ata_dout_oe | output | 1 | Drive data bus enable |

## Verification
The hardest case is a stale or mis-ordered high byte. A fault that shows up only when a latch value from one access leaks into a later one needs a particular ordering of accesses across clock edges. The stimulus therefore interleaves captures, latch loads, task-file accesses, spare-window writes and idle qualifier cycles with the drive bus still carrying distinct words. It then reads offset 8 or writes offset 0, which exposes whatever the latch holds. Every one of the eight control combinations is also applied at both a drive offset and a spare offset.

// File: rtl/hsab_pkg.sv
package hsab_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    TGT_DATA    = 3'd0,
    TGT_TASK    = 3'd1,
    TGT_HILATCH = 3'd2,
    TGT_SPARE   = 3'd3
  } tgt_e;

endpackage

// File: rtl/hsab_strobe_decode.sv
module hsab_strobe_decode
  import hsab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dev_sel_n,
  input  logic phase_n,
  input  logic host_rw,
  input  logic drive_hit,
  output acc_e acc,
  output logic ior_n,
  output logic iow_n
);

  logic qualified;

  always_comb begin
    qualified = ~dev_sel_n & ~phase_n;
    if (!qualified)   acc = ACC_IDLE;
    else if (host_rw) acc = ACC_READ;
    else              acc = ACC_WRITE;
  end

  always_comb begin
    ior_n = ~((acc == ACC_READ) & drive_hit);
    iow_n = ~((acc == ACC_WRITE) & drive_hit);
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ior_n && !iow_n)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel_n || phase_n) |-> (ior_n && iow_n)); // R5
  AST_IOR_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n |-> (host_rw && !dev_sel_n && !phase_n)); // R3
  AST_IOW_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !iow_n |-> (!host_rw && !dev_sel_n && !phase_n)); // R4

endmodule

// File: rtl/hsab_addr_map.sv
module hsab_addr_map
  import hsab_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int REG_AW    = 3,
  parameter int HI_OFFSET = 8
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  acc_e              acc,
  output logic [REG_AW-1:0] da,
  output tgt_e              tgt,
  output logic              drive_hit,
  output logic              cap_en,
  output logic              hi_wr_en
);

  localparam int                WIN   = 1 << REG_AW;
  localparam logic [ADDR_W-1:0] WIN_L = ADDR_W'(WIN);
  localparam logic [ADDR_W-1:0] HI_L  = ADDR_W'(HI_OFFSET);

  always_comb begin
    da        = host_addr[REG_AW-1:0];
    drive_hit = (host_addr < WIN_L);
    if (drive_hit) begin
      if (da == '0) tgt = TGT_DATA;
      else          tgt = TGT_TASK;
    end else if (host_addr == HI_L) begin
      tgt = TGT_HILATCH;
    end else begin
      tgt = TGT_SPARE;
    end
    cap_en   = (acc == ACC_READ)  && (tgt == TGT_DATA);
    hi_wr_en = (acc == ACC_WRITE) && (tgt == TGT_HILATCH);
  end

endmodule

// File: rtl/hsab_byte_latch.sv
module hsab_byte_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_byte,
  input  logic              hi_wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] hi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_q <= '0;
    else if (cap_en)   hi_q <= cap_byte;
    else if (hi_wr_en) hi_q <= wr_byte;
  end

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (hi_q == $past(cap_byte))); // R6
  AST_HOST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr_en && !cap_en) |=> (hi_q == $past(wr_byte))); // R7
  AST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr_en && !cap_en) |=> $stable(hi_q)); // R10

endmodule

// File: rtl/hostslot_ata_bridge.sv
module hostslot_ata_bridge
  import hsab_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int REG_AW    = 3,
  parameter int DATA_W    = 8,
  parameter int HI_OFFSET = 8,
  localparam int WORD_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel_n,
  input  logic              phase_n,
  input  logic              host_rw,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_rd_oe,
  output logic              ata_cs_n,
  output logic [REG_AW-1:0] ata_da,
  output logic              ata_ior_n,
  output logic              ata_iow_n,
  input  logic [WORD_W-1:0] ata_din,
  output logic [WORD_W-1:0] ata_dout,
  output logic              ata_dout_oe
);

  acc_e              acc;
  tgt_e              tgt;
  logic              drive_hit;
  logic              cap_en;
  logic              hi_wr_en;
  logic [DATA_W-1:0] hi_q;

  hsab_strobe_decode u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_sel_n (dev_sel_n),
    .phase_n   (phase_n),
    .host_rw   (host_rw),
    .drive_hit (drive_hit),
    .acc       (acc),
    .ior_n     (ata_ior_n),
    .iow_n     (ata_iow_n)
  );

  hsab_addr_map #(
    .ADDR_W    (ADDR_W),
    .REG_AW    (REG_AW),
    .HI_OFFSET (HI_OFFSET)
  ) u_map (
    .host_addr (host_addr),
    .acc       (acc),
    .da        (ata_da),
    .tgt       (tgt),
    .drive_hit (drive_hit),
    .cap_en    (cap_en),
    .hi_wr_en  (hi_wr_en)
  );

  hsab_byte_latch #(
    .DATA_W (DATA_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_byte (ata_din[WORD_W-1:DATA_W]),
    .hi_wr_en (hi_wr_en),
    .wr_byte  (host_wr_data),
    .hi_q     (hi_q)
  );

  assign ata_cs_n = dev_sel_n;

  always_comb begin
    host_rd_oe   = (acc == ACC_READ);
    host_rd_data = '0;
    if (host_rd_oe) begin
      unique case (tgt)
        TGT_DATA, TGT_TASK: host_rd_data = ata_din[DATA_W-1:0];
        TGT_HILATCH:        host_rd_data = hi_q;
        default:            host_rd_data = '0;
      endcase
    end
  end

  always_comb begin
    ata_dout_oe = ~ata_iow_n;
    if (tgt == TGT_DATA) ata_dout = {hi_q, host_wr_data};
    else                 ata_dout = {{DATA_W{1'b0}}, host_wr_data};
  end

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_oe |-> (!dev_sel_n && !phase_n && host_rw)); // R8
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_oe |-> (host_rd_data == '0)); // R8
  AST_SPARE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr[ADDR_W-1] |-> (ata_ior_n && ata_iow_n)); // R11

endmodule

// File: tb/tb_hostslot_ata_bridge.sv
module tb_hostslot_ata_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_sel_n = 1'b1;
  logic        phase_n = 1'b1;
  logic        host_rw = 1'b1;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wr_data = '0;
  logic [7:0]  host_rd_data;
  logic        host_rd_oe;
  logic        ata_cs_n;
  logic [2:0]  ata_da;
  logic        ata_ior_n;
  logic        ata_iow_n;
  logic [15:0] ata_din = '0;
  logic [15:0] ata_dout;
  logic        ata_dout_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_hi = 8'h00;

  typedef struct {
    logic        ior, iow, cs, oe, dout_oe;
    logic [2:0]  da;
    logic [7:0]  rd;
    logic [15:0] dout;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  hostslot_ata_bridge dut (
    .clk(clk), .rst_n(rst_n), .dev_sel_n(dev_sel_n), .phase_n(phase_n),
    .host_rw(host_rw), .host_addr(host_addr), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .host_rd_oe(host_rd_oe), .ata_cs_n(ata_cs_n),
    .ata_da(ata_da), .ata_ior_n(ata_ior_n), .ata_iow_n(ata_iow_n),
    .ata_din(ata_din), .ata_dout(ata_dout), .ata_dout_oe(ata_dout_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one host cycle at a falling edge and queues the expected outputs.
  task automatic drive(input logic dsel, input logic ph, input logic rw,
                       input logic [3:0] a, input logic [7:0] wd,
                       input logic [15:0] din, input string tag);
    exp_t e;
    logic act, hit, rda, wra;
    @(negedge clk);
    dev_sel_n = dsel; phase_n = ph; host_rw = rw; host_addr = a;
    host_wr_data = wd; ata_din = din;
    act = !dsel && !ph; hit = (a < 4'd8); rda = act && rw; wra = act && !rw;
    e.ior = !(rda && hit);
    e.iow = !(wra && hit);
    e.cs = dsel; e.da = a[2:0]; e.oe = rda;
    if (!rda)          e.rd = 8'h00;
    else if (hit)      e.rd = din[7:0];
    else if (a == 4'd8) e.rd = m_hi;
    else               e.rd = 8'h00;
    e.dout_oe = wra && hit;
    e.dout = (a == 4'd0) ? {m_hi, wd} : {8'h00, wd};
    e.tag = tag;
    q.push_back(e);
    if (rda && a == 4'd0) m_hi = din[15:8];
    if (wra && a == 4'd8) m_hi = wd;
  endtask

  // Monitor: samples after each rising edge and compares with the oldest queued item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(ata_ior_n === e.ior, "R3", {e.tag, " ior_n"}, 16'(ata_ior_n), 16'(e.ior));
        chk(ata_iow_n === e.iow, "R4", {e.tag, " iow_n"}, 16'(ata_iow_n), 16'(e.iow));
        chk(!(ata_ior_n === 1'b0 && ata_iow_n === 1'b0), "R5", {e.tag, " exclusive"},
            16'({ata_ior_n, ata_iow_n}), 16'b11);
        chk(ata_cs_n === e.cs, "R1", {e.tag, " cs_n"}, 16'(ata_cs_n), 16'(e.cs));
        chk(ata_da === e.da, "R2", {e.tag, " da"}, 16'(ata_da), 16'(e.da));
        chk(host_rd_oe === e.oe, "R8", {e.tag, " rd_oe"}, 16'(host_rd_oe), 16'(e.oe));
        chk(host_rd_data === e.rd, "R6", {e.tag, " rd_data"}, 16'(host_rd_data), 16'(e.rd));
        chk(ata_dout_oe === e.dout_oe, "R7", {e.tag, " dout_oe"},
            16'(ata_dout_oe), 16'(e.dout_oe));
        if (e.dout_oe)
          chk(ata_dout === e.dout, "R7", {e.tag, " dout"}, ata_dout, e.dout);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ata_ior_n === 1'b1 && ata_iow_n === 1'b1, "R5", "reset strobes",
        16'({ata_ior_n, ata_iow_n}), 16'b11);
    chk(host_rd_oe === 1'b0, "R8", "reset rd_oe", 16'(host_rd_oe), 16'h0);
    rst_n = 1'b1;

    // R9: latch is empty after reset
    drive(0, 0, 1, 4'd8, 8'h00, 16'hDEAD, "R9 hi after reset");

    // R3 R4 R5: every control combination at a drive offset and a spare offset
    for (int c = 0; c < 8; c++) begin
      drive(c[2], c[1], c[0], 4'd3, 8'h5A, 16'h1234, "R5 table drive");
      drive(c[2], c[1], c[0], 4'd12, 8'hA5, 16'h4321, "R11 table spare");
    end
    drive(1, 1, 1, 4'd0, 8'h00, 16'h0000, "R9 check hi clean");
    drive(0, 0, 1, 4'd8, 8'h00, 16'hFFFF, "R9 hi still zero");

    // R6: capture then collect, with an intervening task register read
    drive(0, 0, 1, 4'd0, 8'h00, 16'hBEEF, "R6 data read");
    drive(0, 0, 1, 4'd7, 8'h00, 16'h9911, "R10 task read");
    drive(1, 0, 1, 4'd0, 8'h00, 16'h7777, "R5 deselected");
    drive(0, 1, 1, 4'd0, 8'h00, 16'h6666, "R5 phase high");
    drive(0, 0, 1, 4'd8, 8'h00, 16'h0000, "R6 hi collect");

    // R7: load latch then full word write
    drive(0, 0, 0, 4'd8, 8'hC3, 16'h0000, "R7 hi load");
    drive(0, 0, 0, 4'd5, 8'h3C, 16'h0000, "R10 task write");
    drive(0, 0, 0, 4'd13, 8'h99, 16'h0000, "R11 spare write");
    drive(0, 0, 0, 4'd0, 8'h81, 16'h0000, "R7 data write");
    drive(0, 0, 1, 4'd8, 8'h00, 16'h0000, "R7 hi kept");

    // Second word with distinct patterns, back to back
    drive(0, 0, 1, 4'd0, 8'h00, 16'h0155, "R6 data read 2");
    drive(0, 0, 1, 4'd0, 8'h00, 16'hFE01, "R6 data read 3");
    drive(0, 0, 1, 4'd8, 8'h00, 16'h0000, "R6 hi collect 2");
    drive(0, 0, 0, 4'd0, 8'h42, 16'h0000, "R7 write reuse hi");
    drive(0, 0, 1, 4'd9, 8'h00, 16'hABCD, "R11 spare read");
    drive(0, 0, 0, 4'd8, 8'h10, 16'h0000, "R7 hi load 2");
    drive(0, 0, 0, 4'd0, 8'h20, 16'h0000, "R7 data write 2");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule